// File: doc/BRIEF.md
# Gated External-Clock Serial Result Readout

This block is the serial output stage of a two-channel converter for the case where the host supplies the serial clock. The converter core hands over a pair of 16-bit results with a one-cycle completion strobe once the second channel finishes. The block keeps that pair as a 32-bit word and shifts it out, most significant bit first, on rising edges of the host clock. The channel A bits come first, then the channel B bits.

The host clock, chip select and read inputs are asynchronous to the system clock. Each is passed through a synchronizer and edge-detected in the system clock domain. A host clock edge moves the shift register only while chip select is low. The data pin is driven only while chip select and read are both low. The host clock may run continuously or in bursts, and a burst clock may idle high or low. The host chooses when to take a result by where it places chip select: right after completion, or during the next conversion. A result that completes while a frame is being read does not disturb that frame. It waits until the frame ends.

Top module: `serial_slave_readout`

## Requirements
- R1: While `ext_mode_i` is low the block is deselected. `sdout_oe_o` stays low, `sdout_o` stays 0, and host clock edges do not move the shift register.
- R2: `sdout_oe_o` is high only when `ext_mode_i` is high and the synchronized `cs_n_i` and `rd_n_i` are both low. While it is low, `sdout_o` is 0.
- R3: A frame is 32 bits: channel A bit 15 down to bit 0, then channel B bit 15 down to bit 0. `sdout_o` shows channel A bit 15 as soon as the output is enabled.
- R4: Each rising edge of `sclk_i` seen while chip select is low advances the frame by one bit. Edges seen while chip select is high, including those of a free-running clock, are ignored.
- R5: A falling `sclk_i` edge never advances the frame, so a burst clock that idles high reads the same 32 bits as one that idles low.
- R6: A rising edge on `cs_n_i` ends the frame early. The next frame restarts at channel A bit 15 of the latest result.
- R7: A `conv_done_i` pulse while no frame is open loads {`ch_a_i`, `ch_b_i`} so that the next frame carries it.
- R8: A `conv_done_i` pulse while a frame is open leaves that frame's remaining bits unchanged. The new result appears from the next frame, whether the frame ends after 32 bits or through chip select rising.
- R9: After the 32nd advancing edge, the frame reloads the latest result and continues from its channel A bit 15.
- R10: With chip select low and read high, the output is released but host clock edges still advance the frame.
- R11: After reset the output is released, `sdout_o` is 0, and the stored result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode_i | input | 1 | High selects the host-clocked readout |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rd_n_i | input | 1 | Read enable, active low, asynchronous |
| conv_done_i | input | 1 | One-cycle strobe: a channel B conversion has finished |
| ch_a_i | input | 16 | Channel A result, valid with the strobe |
| ch_b_i | input | 16 | Channel B result, valid with the strobe |
| sdout_o | output | 1 | Serial data, 0 while released |
| sdout_oe_o | output | 1 | Output enable for the data pin |

## Verification
A change on `sclk_i` takes effect at `sdout_o` on the third rising system clock edge after it: two synchronizer edges, then the registered shift. A change on `cs_n_i` or `rd_n_i` reaches `sdout_oe_o` on the second edge. A completion strobe is taken on the edge where it is high. The bench reference model keeps a history of the inputs, reads the entries two and three edges back to decide advance and restart, and uses the entry one edge back for the enable. Its predictions are compared 3 ns after each falling edge. The directed host reads hold each clock phase for four system cycles, which covers the three-edge latency before a bit is sampled.

// File: rtl/srd_pkg.sv
// Shared constants and types for the gated serial result readout.
// Assumes: one frame carries two channel words of equal width.
package srd_pkg;
    localparam int unsigned CH_W       = 16;
    localparam int unsigned FRAME_W    = 2 * CH_W;
    localparam int unsigned SYNC_DEPTH = 2;

    // Host pins gathered for one synchronizer, in this bit order.
    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic rd_n;
    } host_pins_t;

    localparam host_pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, rd_n: 1'b1};
endpackage

// File: rtl/srd_sync.sv
// Multi-bit flop-chain synchronizer for quasi-static or slow host pins.
// Assumes: each bit is independent; reset loads RST_VAL into every stage.
module srd_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift the pin values along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srd_gate.sv
// Turns synchronized host pins into per-cycle events: advance one bit,
// restart the frame, and frame-open level.
// Assumes: inputs are already synchronized to clk.
module srd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic s_sclk,
    input  logic s_cs_n,
    output logic adv,
    output logic restart,
    output logic in_frame
);
    logic sclk_d;
    logic cs_d;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= s_sclk;
            cs_d   <= s_cs_n;
        end
    end

    assign adv      = ext_mode & s_sclk & ~sclk_d & ~s_cs_n;
    assign restart  = s_cs_n & ~cs_d;
    assign in_frame = ext_mode & ~s_cs_n;
endmodule

// File: rtl/srd_shift.sv
// Holds the latest result pair and the frame shift register with its bit
// counter. Loads a fresh result straight away only when no frame is open.
// Assumes: adv and restart are never high together with an open-frame load.
module srd_shift #(
    parameter int unsigned CH_W    = srd_pkg::CH_W,
    parameter int unsigned FRAME_W = 2 * CH_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            restart,
    input  logic            in_frame,
    input  logic            res_valid,
    input  logic [CH_W-1:0] ch_a,
    input  logic [CH_W-1:0] ch_b,
    output logic            msb
);
    localparam int unsigned CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] hold;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] fresh;
    logic [FRAME_W-1:0] load_val;
    logic               frame_end;

    assign fresh     = {ch_a, ch_b};
    assign load_val  = res_valid ? fresh : hold;
    assign frame_end = restart | (adv & (bit_cnt == LAST));

    // Keep the most recent completed result.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold <= '0;
        else if (res_valid) hold <= fresh;
    end

    // Shift one bit per advance, reload at frame end or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (frame_end) begin
            shreg   <= load_val;
            bit_cnt <= '0;
        end else if (adv) begin
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end else if (res_valid && !in_frame) begin
            shreg   <= fresh;
        end
    end

    assign msb = shreg[FRAME_W-1];

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !restart) |=> $stable(bit_cnt));                        // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !restart && bit_cnt != LAST) |=> bit_cnt == $past(bit_cnt) + CNT_W'(1)); // R4
    AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !restart && bit_cnt != LAST) |=> shreg == {$past(shreg[FRAME_W-2:0]), 1'b0}); // R3
    AST_WRAP_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && bit_cnt == LAST) |=> bit_cnt == '0);                     // R9
    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> bit_cnt == '0);                                      // R6
    AST_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !adv && !restart) |=> $stable(shreg));              // R8
endmodule

// File: rtl/serial_slave_readout.sv
// Top of the host-clocked serial result readout: synchronizes the host
// pins, detects clock and select edges, and drives the gated data pin.
// Assumes: ext_mode_i is quasi-static; conv_done_i is in the clk domain.
module serial_slave_readout #(
    parameter int unsigned CH_W       = srd_pkg::CH_W,
    parameter int unsigned SYNC_DEPTH = srd_pkg::SYNC_DEPTH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_mode_i,
    input  logic            sclk_i,
    input  logic            cs_n_i,
    input  logic            rd_n_i,
    input  logic            conv_done_i,
    input  logic [CH_W-1:0] ch_a_i,
    input  logic [CH_W-1:0] ch_b_i,
    output logic            sdout_o,
    output logic            sdout_oe_o
);
    localparam int unsigned FRAME_W = 2 * CH_W;
    localparam int unsigned PIN_W   = $bits(srd_pkg::host_pins_t);

    srd_pkg::host_pins_t raw_pins;
    srd_pkg::host_pins_t s_pins;
    logic                adv;
    logic                restart;
    logic                in_frame;
    logic                msb;

    assign raw_pins = '{sclk: sclk_i, cs_n: cs_n_i, rd_n: rd_n_i};

    srd_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(srd_pkg::PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_pins),
        .q    (s_pins)
    );

    srd_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_mode(ext_mode_i),
        .s_sclk  (s_pins.sclk),
        .s_cs_n  (s_pins.cs_n),
        .adv     (adv),
        .restart (restart),
        .in_frame(in_frame)
    );

    srd_shift #(
        .CH_W   (CH_W),
        .FRAME_W(FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .restart  (restart),
        .in_frame (in_frame),
        .res_valid(conv_done_i),
        .ch_a     (ch_a_i),
        .ch_b     (ch_b_i),
        .msb      (msb)
    );

    assign sdout_oe_o = ext_mode_i & ~s_pins.cs_n & ~s_pins.rd_n;
    assign sdout_o    = sdout_oe_o & msb;

    AST_NO_ADV_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_i |-> !adv);                                           // R1
    AST_NO_ADV_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        s_pins.cs_n |-> !adv);                                           // R4
endmodule

// File: tb/sim_serial_slave_readout.sv
module sim_serial_slave_readout;
    localparam int PH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        rv = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        sd;
    logic        oe;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R11";
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    serial_slave_readout u0 (
        .clk(clk), .rst_n(rst_n), .ext_mode_i(ext), .sclk_i(sclk),
        .cs_n_i(cs_n), .rd_n_i(rd_n), .conv_done_i(rv),
        .ch_a_i(a), .ch_b_i(b), .sdout_o(sd), .sdout_oe_o(oe)
    );

    // Behavioural reference: input history, frame word, bit index.
    logic [2:0]  hist[$];
    logic [31:0] m_sh = '0;
    logic [31:0] m_hold = '0;
    int          m_cnt = 0;
    logic        m_cs1 = 1'b1;
    logic        m_rd1 = 1'b1;
    logic [2:0]  h2, h3;
    logic        m_adv, m_rst, m_open;
    logic [31:0] m_new, m_load;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b011, 3'b011, 3'b011, 3'b011};
            m_sh = '0; m_hold = '0; m_cnt = 0;
        end else begin
            hist.push_front({sclk, cs_n, rd_n});
            void'(hist.pop_back());
            h2 = hist[2]; h3 = hist[3];
            m_adv  = ext && h2[2] && !h3[2] && !h2[1];
            m_rst  = h2[1] && !h3[1];
            m_open = ext && !h2[1];
            m_new  = {a, b};
            m_load = rv ? m_new : m_hold;
            if (rv) m_hold = m_new;
            if (m_rst || (m_adv && m_cnt == 31)) begin
                m_cnt = 0; m_sh = m_load;
            end else if (m_adv) begin
                m_sh = m_sh << 1; m_cnt++;
            end else if (rv && !m_open) begin
                m_sh = m_new;
            end
        end
        m_cs1 = hist[1][1];
        m_rd1 = hist[1][0];
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference model.
    logic e_oe, e_sd;
    always @(negedge clk) begin
        #3;
        if (rst_n && hist.size() == 4 && !finished) begin
            e_oe = ext && !m_cs1 && !m_rd1;
            e_sd = e_oe && m_sh[31];
            check({cur_req, " oe"}, 32'(oe), 32'(e_oe));
            check({cur_req, " sd"}, 32'(sd), 32'(e_sd));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(logic [15:0] x, logic [15:0] y);
        @(negedge clk); a = x; b = y; rv = 1'b1;
        @(negedge clk); rv = 1'b0;
    endtask

    task automatic shift_bits(int n, bit idle_hi, output logic [31:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            w = {w[30:0], sd};
            if (idle_hi) begin
                sclk = 1'b0; tick(PH); sclk = 1'b1; tick(PH);
            end else begin
                sclk = 1'b1; tick(PH); sclk = 1'b0; tick(PH);
            end
        end
    endtask

    task automatic open_frame(bit rd_low);
        cs_n = 1'b0; rd_n = !rd_low; tick(PH);
    endtask

    task automatic close_frame(bit idle_hi);
        cs_n = 1'b1; rd_n = 1'b1; sclk = idle_hi; tick(PH);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    logic [31:0] w, w1, w2;
    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R11: reset state at the pins
        check("R11", {30'd0, oe, sd}, 32'd0);

        // R1: deselected, edges must not move the word
        cur_req = "R1";
        load(16'h1234, 16'hABCD);
        cs_n = 1'b0; rd_n = 1'b0; tick(PH);
        check("R1", 32'(oe), 32'd0);
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; tick(PH); sclk = 1'b0; tick(PH);
        end
        check("R1", 32'(oe), 32'd0);
        cs_n = 1'b1; rd_n = 1'b1; tick(PH);
        ext = 1'b1; tick(2);

        // R3: full frame, idle-low clock, MSB first A then B
        cur_req = "R3";
        open_frame(1'b1);
        check("R3", 32'(sd), 32'd0);  // 0x1234 bit 15 is 0
        shift_bits(32, 1'b0, w);
        check("R3", w, 32'h1234ABCD);

        // R9: continue past the end, reload restarts at A15
        cur_req = "R9";
        shift_bits(16, 1'b0, w);
        check("R9", w, 32'h00001234);
        close_frame(1'b0);

        // R5: idle-high burst clock
        cur_req = "R5";
        sclk = 1'b1; tick(PH);
        open_frame(1'b1);
        shift_bits(32, 1'b1, w);
        check("R5", w, 32'h1234ABCD);
        close_frame(1'b1);
        sclk = 1'b0; tick(PH);

        // R4: free-running clock while chip select is high
        cur_req = "R4";
        for (int i = 0; i < 12; i++) begin
            sclk = 1'b1; tick(PH); sclk = 1'b0; tick(PH);
        end
        open_frame(1'b1);
        shift_bits(32, 1'b0, w);
        check("R4", w, 32'h1234ABCD);
        close_frame(1'b0);

        // R6: aborted frame restarts at A15
        cur_req = "R6";
        open_frame(1'b1);
        shift_bits(5, 1'b0, w);
        close_frame(1'b0);
        open_frame(1'b1);
        shift_bits(32, 1'b0, w);
        check("R6", w, 32'h1234ABCD);
        close_frame(1'b0);

        // R8: new result mid-frame, frame ended by 32 bits
        cur_req = "R8";
        open_frame(1'b1);
        shift_bits(10, 1'b0, w1);
        load(16'h5A5A, 16'hC3C3);
        shift_bits(22, 1'b0, w2);
        check("R8", {w1[9:0], w2[21:0]}, 32'h1234ABCD);
        shift_bits(32, 1'b0, w);
        check("R8", w, 32'h5A5AC3C3);
        close_frame(1'b0);

        // R8: new result mid-frame, frame ended by chip select
        open_frame(1'b1);
        shift_bits(4, 1'b0, w1);
        load(16'h0F0F, 16'hF0F0);
        shift_bits(4, 1'b0, w2);
        check("R8", {24'd0, w1[3:0], w2[3:0]}, 32'h0000005A);
        close_frame(1'b0);
        open_frame(1'b1);
        shift_bits(32, 1'b0, w);
        check("R8", w, 32'h0F0FF0F0);
        close_frame(1'b0);

        // R10: read high releases the pin but the clock still shifts
        cur_req = "R10";
        open_frame(1'b0);
        check("R10", 32'(oe), 32'd0);
        shift_bits(8, 1'b0, w);
        check("R2", w, 32'd0);  // released pin reads 0
        rd_n = 1'b0; tick(PH);
        shift_bits(24, 1'b0, w);
        check("R10", w, 32'h000FF0F0);
        close_frame(1'b0);

        // R2: enable needs both selects low
        cur_req = "R2";
        rd_n = 1'b0; tick(PH);
        check("R2", 32'(oe), 32'd0);
        cs_n = 1'b0; tick(PH);
        check("R2", 32'(oe), 32'd1);
        close_frame(1'b0);

        // R7: result completed with no frame open
        cur_req = "R7";
        load(16'hBEEF, 16'h0001);
        tick(2);
        open_frame(1'b1);
        shift_bits(32, 1'b0, w);
        check("R7", w, 32'hBEEF0001);
        close_frame(1'b0);

        summary();
        $finish;
    end
endmodule